// File: doc/BRIEF.md
# Registered Integer ALU with Condition Flags

This block is the arithmetic stage of a small processor pipeline. On each cycle with the enable high, it takes two operands and a four-bit operation code. It registers one result word and the working state behind four condition flags: zero, carry, negative and overflow. The flags are formed combinationally from that registered state, so they are valid in the same cycle as the result. When the enable is low, every register keeps its value. A synchronous reset clears all of them.

The operations are subtract (also used for compare), AND, add, OR and XOR. There are three shifts: logical right, logical left and arithmetic right. Each shift reads the whole second operand as its distance, not only its low bits. There is also a bit reversal of the second operand, used as the first half of a two-step constant load. A half-word merge keeps the upper half of the first operand and takes the lower half of the second. Every opcode from 10 to 15 passes the second operand through unchanged.

Two points set this block apart. The negative flag is corrected after a signed add or subtract overflows, so a signed less-than test based on it still gives the right answer. The overflow flag also goes high when a logical shift changes the sign bit.

Top module: `alu_core`

## Requirements
- R1: Opcode 1 gives a AND b, opcode 3 gives a OR b, opcode 4 gives a XOR b, and every opcode from 10 to 15 gives b unchanged. All of these leave carry and overflow clear.
- R2: Opcode 0 gives a minus b modulo 2^32. Carry is high exactly when unsigned b is greater than unsigned a, which is a borrow.
- R3: Opcode 2 gives a plus b modulo 2^32. Carry is high exactly when the unsigned sum does not fit in 32 bits.
- R4: Opcode 5 is a logical right shift and opcode 6 is a logical left shift, both with zero fill. The distance is the full 32-bit value of b. Carry is the last bit shifted out. A distance of 0 gives a with carry clear. A distance of exactly 32 gives zero, with carry set to a[31] for the right shift and to a[0] for the left shift. Any larger distance gives zero with carry clear.
- R5: Opcode 7 shifts right and fills from a[31]. Carry is the last bit shifted out. A distance of 32 or more gives 32 copies of a[31], with carry equal to a[31].
- R6: Opcode 8 gives b with bit k moved to bit 31-k. Opcode 9 gives {a[31:16], b[15:0]}.
- R7: For every opcode other than 0, 2, 5, 6 and 7, carry is cleared.
- R8: The zero flag is high exactly when the registered result is zero.
- R9: For add and subtract, the negative flag equals the sign of the exact, unbounded signed result. For example, 0x7FFFFFFF minus 0x80000000 gives a clear negative flag. For all other opcodes, it equals result bit 31.
- R10: The overflow flag is high only in two cases. The first is a signed add or subtract whose exact result does not fit in 32 bits. The second is a logical shift (opcode 5 or 6) whose result bit 31 differs from a[31].
- R11: While the enable is low, the result and all four flags hold their values, whatever the operands and opcode are.
- R12: A synchronous reset gives result 0, zero flag high, and carry, negative and overflow low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Enable; the operation is captured on a rising edge while this is high |
| op | input | 4 | Operation code |
| a | input | 32 | First operand |
| b | input | 32 | Second operand; also the shift distance |
| result | output | 32 | Registered result |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry or borrow flag |
| flag_n | output | 1 | Negative flag, corrected for signed overflow |
| flag_v | output | 1 | Overflow flag |

## Verification
The bench targets the overflow boundaries: 0x7FFFFFFF minus 0x80000000, 0x80000000 minus 1, and 0x7FFFFFFF plus 1. A design that takes the negative flag straight from the result sign reports the wrong sign on these. A design that forgets the shift case of the overflow rule stays silent when a logical shift flips bit 31. Shift distances of 0, 1, 31, 32, 33 and 256 catch two faults: a shifter that looks only at the low five bits of b, which would wrap instead of clearing the result, and the wrong bit taken as carry at exactly 32. Further checks cover carry that leaks from an add into a following AND, results that change while the enable is low, and the multiply-range opcodes, which must behave as a move.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_SUB   = 4'd0,
        OP_AND   = 4'd1,
        OP_ADD   = 4'd2,
        OP_OR    = 4'd3,
        OP_XOR   = 4'd4,
        OP_LSR   = 4'd5,
        OP_LSL   = 4'd6,
        OP_ASR   = 4'd7,
        OP_BREV  = 4'd8,
        OP_MERGE = 4'd9
    } alu_op_e;

endpackage

// File: rtl/alu_shift_unit.sv
module alu_shift_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic [WIDTH-1:0] dist_i,
    output logic [WIDTH-1:0] lsr_o,
    output logic             lsr_c_o,
    output logic [WIDTH-1:0] lsl_o,
    output logic             lsl_c_o,
    output logic [WIDTH-1:0] asr_o,
    output logic             asr_c_o
);
    localparam int SHW = $clog2(WIDTH);
    localparam int unsigned WI = WIDTH;
    localparam logic [WIDTH-1:0] WIDTH_V = WIDTH'(WI);

    logic [SHW-1:0]      sh;
    logic                exact;
    logic                beyond;
    logic [WIDTH:0]      r_tmp;
    logic [WIDTH:0]      l_tmp;
    logic signed [WIDTH:0] a_tmp;
    logic                sgn;

    always_comb begin
        sh     = dist_i[SHW-1:0];
        exact  = (dist_i == WIDTH_V);
        beyond = (dist_i > WIDTH_V);
        sgn    = val_i[WIDTH-1];
        r_tmp  = {val_i, 1'b0} >> sh;
        l_tmp  = {1'b0, val_i} << sh;
        a_tmp  = $signed({val_i, 1'b0}) >>> sh;

        if (beyond) begin
            lsr_o   = '0;
            lsr_c_o = 1'b0;
            lsl_o   = '0;
            lsl_c_o = 1'b0;
        end else if (exact) begin
            lsr_o   = '0;
            lsr_c_o = val_i[WIDTH-1];
            lsl_o   = '0;
            lsl_c_o = val_i[0];
        end else begin
            lsr_o   = r_tmp[WIDTH:1];
            lsr_c_o = r_tmp[0];
            lsl_o   = l_tmp[WIDTH-1:0];
            lsl_c_o = l_tmp[WIDTH];
        end

        if (beyond || exact) begin
            asr_o   = {WIDTH{sgn}};
            asr_c_o = sgn;
        end else begin
            asr_o   = a_tmp[WIDTH:1];
            asr_c_o = a_tmp[0];
        end
    end

endmodule

// File: rtl/alu_data_unit.sv
module alu_data_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             sum_c_o,
    output logic [WIDTH-1:0] diff_o,
    output logic             diff_c_o,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o,
    output logic [WIDTH-1:0] xor_o,
    output logic [WIDTH-1:0] brev_o,
    output logic [WIDTH-1:0] merge_o
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH:0] sum_ext;
    logic [WIDTH:0] diff_ext;

    always_comb begin
        sum_ext  = {1'b0, a_i} + {1'b0, b_i};
        diff_ext = {1'b0, a_i} - {1'b0, b_i};
        sum_o    = sum_ext[WIDTH-1:0];
        sum_c_o  = sum_ext[WIDTH];
        diff_o   = diff_ext[WIDTH-1:0];
        diff_c_o = diff_ext[WIDTH];
        and_o    = a_i & b_i;
        or_o     = a_i | b_i;
        xor_o    = a_i ^ b_i;
        merge_o  = {a_i[WIDTH-1:HALF], b_i[HALF-1:0]};
    end

    for (genvar k = 0; k < WIDTH; k++) begin : g_rev
        assign brev_o[k] = b_i[WIDTH-1-k];
    end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] res_i,
    input  logic             carry_i,
    input  logic             sign_a_i,
    input  logic             keep_sign_i,
    input  logic             ovf_arm_i,
    output logic             z_o,
    output logic             c_o,
    output logic             n_o,
    output logic             v_o
);
    logic top;
    logic flipped;

    always_comb begin
        top     = res_i[WIDTH-1];
        flipped = (sign_a_i != top);
        z_o     = (res_i == '0);
        c_o     = carry_i;
        n_o     = top ^ (keep_sign_i & flipped);
        v_o     = ovf_arm_i & flipped;
    end

endmodule

// File: rtl/alu_core.sv
module alu_core #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] result,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_n,
    output logic             flag_v
);
    import alu_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             carry;
        logic             sign_a;
        logic             keep_sign;
        logic             ovf_arm;
    } alu_state_t;

    alu_state_t st_d, st_q;

    logic [WIDTH-1:0] sum_w, diff_w, and_w, or_w, xor_w, brev_w, merge_w;
    logic [WIDTH-1:0] lsr_w, lsl_w, asr_w;
    logic             sum_c_w, diff_c_w, lsr_c_w, lsl_c_w, asr_c_w;
    logic             sgn_a, sgn_b;

    alu_data_unit #(.WIDTH(WIDTH)) u_data (
        .a_i      (a),
        .b_i      (b),
        .sum_o    (sum_w),
        .sum_c_o  (sum_c_w),
        .diff_o   (diff_w),
        .diff_c_o (diff_c_w),
        .and_o    (and_w),
        .or_o     (or_w),
        .xor_o    (xor_w),
        .brev_o   (brev_w),
        .merge_o  (merge_w)
    );

    alu_shift_unit #(.WIDTH(WIDTH)) u_shift (
        .val_i   (a),
        .dist_i  (b),
        .lsr_o   (lsr_w),
        .lsr_c_o (lsr_c_w),
        .lsl_o   (lsl_w),
        .lsl_c_o (lsl_c_w),
        .asr_o   (asr_w),
        .asr_c_o (asr_c_w)
    );

    always_comb begin
        st_d  = st_q;
        sgn_a = a[WIDTH-1];
        sgn_b = b[WIDTH-1];
        if (rst) begin
            st_d = '0;
        end else if (ce) begin
            st_d.carry     = 1'b0;
            st_d.sign_a    = sgn_a;
            st_d.keep_sign = ((op == OP_SUB) && (sgn_a != sgn_b)) ||
                             ((op == OP_ADD) && (sgn_a == sgn_b));
            st_d.ovf_arm   = ((op == OP_SUB) && (sgn_a != sgn_b)) ||
                             ((op == OP_ADD) && (sgn_a == sgn_b)) ||
                             (op == OP_LSR) || (op == OP_LSL);
            case (op)
                OP_SUB:   begin st_d.res = diff_w; st_d.carry = diff_c_w; end
                OP_AND:   st_d.res = and_w;
                OP_ADD:   begin st_d.res = sum_w;  st_d.carry = sum_c_w;  end
                OP_OR:    st_d.res = or_w;
                OP_XOR:   st_d.res = xor_w;
                OP_LSR:   begin st_d.res = lsr_w;  st_d.carry = lsr_c_w;  end
                OP_LSL:   begin st_d.res = lsl_w;  st_d.carry = lsl_c_w;  end
                OP_ASR:   begin st_d.res = asr_w;  st_d.carry = asr_c_w;  end
                OP_BREV:  st_d.res = brev_w;
                OP_MERGE: st_d.res = merge_w;
                default:  st_d.res = b;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign result = st_q.res;

    alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
        .res_i       (st_q.res),
        .carry_i     (st_q.carry),
        .sign_a_i    (st_q.sign_a),
        .keep_sign_i (st_q.keep_sign),
        .ovf_arm_i   (st_q.ovf_arm),
        .z_o         (flag_z),
        .c_o         (flag_c),
        .n_o         (flag_n),
        .v_o         (flag_v)
    );

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             ce,
    input logic [3:0]       op,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [WIDTH-1:0] result,
    input logic             flag_z,
    input logic             flag_c,
    input logic             flag_n,
    input logic             flag_v
);
    function automatic logic true_sign(input logic [WIDTH-1:0] x,
                                       input logic [WIDTH-1:0] y,
                                       input logic sub);
        logic [WIDTH:0] e;
        e = sub ? ({x[WIDTH-1], x} - {y[WIDTH-1], y})
                : ({x[WIDTH-1], x} + {y[WIDTH-1], y});
        return e[WIDTH];
    endfunction

    logic plain_op;
    assign plain_op = (op == 4'd1) || (op == 4'd3) || (op == 4'd4) ||
                      (op == 4'd8) || (op == 4'd9) || (op >= 4'd10);

    // R11: nothing moves while the enable is low
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!ce) |=> ($stable(result) && $stable(flag_c) && $stable(flag_n) && $stable(flag_v)));

    // R12: reset clears the state
    p_reset_r12: assert property (@(posedge clk)
        rst |=> (result == '0 && flag_z && !flag_c && !flag_n && !flag_v));

    // R3: sum and carry together form the unsigned sum
    p_add_r3: assert property (@(posedge clk) disable iff (rst)
        (ce && op == 4'd2) |=> ({flag_c, result} == ({1'b0, $past(a)} + {1'b0, $past(b)})));

    // R2: difference and borrow
    p_sub_r2: assert property (@(posedge clk) disable iff (rst)
        (ce && op == 4'd0) |=> (result == $past(a) - $past(b) && flag_c == ($past(b) > $past(a))));

    // R7 and R10: plain operations leave carry and overflow clear
    p_plain_r7: assert property (@(posedge clk) disable iff (rst)
        (ce && plain_op) |=> (!flag_c && !flag_v));

    // R9: negative flag follows the exact sign of a sum
    p_neg_add_r9: assert property (@(posedge clk) disable iff (rst)
        (ce && op == 4'd2) |=> (flag_n == true_sign($past(a), $past(b), 1'b0)));

    p_neg_sub_r9: assert property (@(posedge clk) disable iff (rst)
        (ce && op == 4'd0) |=> (flag_n == true_sign($past(a), $past(b), 1'b1)));

    // R8: zero flag tracks the result
    p_zero_r8: assert property (@(posedge clk) disable iff (rst)
        flag_z == (result == '0));

endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) i_alu_core_chk (.*);

// File: tb/test_alu_core.sv
`timescale 1ns/1ps
module test_alu_core;

    typedef struct {
        logic [31:0] res;
        logic        z, c, n, v;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce  = 1'b0;
    logic [3:0]  op  = 4'd0;
    logic [31:0] a   = '0;
    logic [31:0] b   = '0;
    logic [31:0] result;
    logic        flag_z, flag_c, flag_n, flag_v;

    int total = 0;
    int bad   = 0;
    exp_t q[$];
    exp_t last;

    always #10 clk = ~clk;

    alu_core i_alu_core (
        .clk(clk), .rst(rst), .ce(ce), .op(op), .a(a), .b(b),
        .result(result), .flag_z(flag_z), .flag_c(flag_c),
        .flag_n(flag_n), .flag_v(flag_v)
    );

    function automatic exp_t model(input logic [3:0] o, input logic [31:0] x,
                                   input logic [31:0] y, input string tag);
        exp_t e;
        logic [32:0] w;
        logic signed [33:0] sx;
        e.tag = tag; e.c = 1'b0; e.v = 1'b0;
        sx = '0;
        case (o)
            4'd0: begin
                w = {1'b0, x} - {1'b0, y}; e.res = w[31:0]; e.c = (y > x);
                sx = $signed({{2{x[31]}}, x}) - $signed({{2{y[31]}}, y});
            end
            4'd1: e.res = x & y;
            4'd2: begin
                w = {1'b0, x} + {1'b0, y}; e.res = w[31:0]; e.c = w[32];
                sx = $signed({{2{x[31]}}, x}) + $signed({{2{y[31]}}, y});
            end
            4'd3: e.res = x | y;
            4'd4: e.res = x ^ y;
            4'd5: begin
                if (y == 0) e.res = x;
                else if (y < 32) begin e.res = x >> y; e.c = x[y-1]; end
                else if (y == 32) begin e.res = 0; e.c = x[31]; end
                else e.res = 0;
            end
            4'd6: begin
                if (y == 0) e.res = x;
                else if (y < 32) begin e.res = x << y; e.c = x[32-y]; end
                else if (y == 32) begin e.res = 0; e.c = x[0]; end
                else e.res = 0;
            end
            4'd7: begin
                if (y == 0) e.res = x;
                else if (y < 32) begin e.res = $signed(x) >>> y; e.c = x[y-1]; end
                else begin e.res = {32{x[31]}}; e.c = x[31]; end
            end
            4'd8: for (int k = 0; k < 32; k++) e.res[k] = y[31-k];
            4'd9: e.res = {x[31:16], y[15:0]};
            default: e.res = y;
        endcase
        e.z = (e.res == 0);
        if (o == 4'd0 || o == 4'd2) begin
            e.n = sx[33];
            e.v = (sx > 34'sh7FFFFFFF) || (sx < -34'sh80000000);
        end else begin
            e.n = e.res[31];
            if (o == 4'd5 || o == 4'd6) e.v = (x[31] != e.res[31]);
        end
        return e;
    endfunction

    task automatic compare(input exp_t e);
        total++;
        if (result !== e.res || flag_z !== e.z || flag_c !== e.c ||
            flag_n !== e.n || flag_v !== e.v) begin
            bad++;
            $display("FAIL %s: got res=%h zcnv=%b%b%b%b exp res=%h zcnv=%b%b%b%b",
                     e.tag, result, flag_z, flag_c, flag_n, flag_v,
                     e.res, e.z, e.c, e.n, e.v);
        end
    endtask

    // driver
    task automatic drive(input logic [3:0] o, input logic [31:0] x,
                         input logic [31:0] y, input string tag);
        @(negedge clk);
        op = o; a = x; b = y; ce = 1'b1;
        last = model(o, x, y, tag);
        q.push_back(last);
    endtask

    // monitor: compares one item per enabled edge
    always @(posedge clk) begin
        if (ce && !rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            #5 compare(e);
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        exp_t rz;
        rz.res = 0; rz.z = 1; rz.c = 0; rz.n = 0; rz.v = 0; rz.tag = "R12 reset state";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #5;
        compare(rz);

        drive(4'd0, 32'd5, 32'd3, "R2 sub small");
        drive(4'd0, 32'd3, 32'd5, "R2 sub borrow");
        drive(4'd0, 32'h7FFFFFFF, 32'h80000000, "R9 sub ovf pos");
        drive(4'd0, 32'h80000000, 32'd1, "R10 sub ovf neg");
        drive(4'd2, 32'hFFFFFFFF, 32'd1, "R3 add wrap zero R8");
        drive(4'd2, 32'h7FFFFFFF, 32'd1, "R10 add ovf");
        drive(4'd2, 32'h80000000, 32'h80000000, "R9 add neg ovf");
        drive(4'd1, 32'hF0F0FFFF, 32'h0FF0F00F, "R7 and after carry R1");
        drive(4'd3, 32'h12340000, 32'h00005678, "R1 or");
        drive(4'd4, 32'hFFFF0000, 32'h0F0F0F0F, "R1 xor");
        drive(4'd15, 32'h11111111, 32'h80000001, "R1 move");
        drive(4'd10, 32'hAAAAAAAA, 32'h00000000, "R1 mul falls to move R8");
        drive(4'd12, 32'hAAAAAAAA, 32'h5555AAAA, "R1 mul low move");
        drive(4'd8, 32'hDEADBEEF, 32'h00000001, "R6 brev");
        drive(4'd8, 32'h0, 32'h12345678, "R6 brev pattern");
        drive(4'd9, 32'hABCD1234, 32'h9999EF01, "R6 merge");
        drive(4'd5, 32'h80000001, 32'd1, "R4 lsr 1");
        drive(4'd5, 32'h80000000, 32'd31, "R4 lsr 31");
        drive(4'd5, 32'h80000000, 32'd32, "R4 lsr 32");
        drive(4'd5, 32'hFFFFFFFF, 32'd33, "R4 lsr 33");
        drive(4'd5, 32'hFFFFFFFF, 32'h100, "R4 lsr 256");
        drive(4'd5, 32'h80000003, 32'd0, "R4 lsr 0");
        drive(4'd6, 32'h40000001, 32'd1, "R4 lsl 1 R10");
        drive(4'd6, 32'h00000001, 32'd32, "R4 lsl 32");
        drive(4'd6, 32'h00000001, 32'd34, "R4 lsl 34");
        drive(4'd6, 32'hC0000000, 32'd1, "R4 lsl carry");
        drive(4'd7, 32'hFFFFFFFE, 32'd1, "R5 asr 1");
        drive(4'd7, 32'h80000000, 32'd40, "R5 asr 40");
        drive(4'd7, 32'h7FFFFFFF, 32'd40, "R5 asr pos 40");
        drive(4'd7, 32'h80000010, 32'd5, "R5 asr 5");
        drive(4'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, "R3 add carry");

        // R11: inputs change with the enable low; outputs must hold
        @(negedge clk);
        ce = 1'b0; op = 4'd0; a = 32'd1; b = 32'd7;
        repeat (2) @(posedge clk);
        #5;
        begin
            exp_t h;
            h = last; h.tag = "R11 hold";
            compare(h);
        end

        // R12: reset in the middle of a run
        @(negedge clk);
        rst = 1'b1; ce = 1'b1; op = 4'd2; a = 32'd9; b = 32'd9;
        @(posedge clk); #5;
        compare(rz);
        @(negedge clk);
        rst = 1'b0; ce = 1'b0;

        drive(4'd0, 32'h80000000, 32'h7FFFFFFF, "R9 sub neg-pos");
        @(negedge clk);
        ce = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule